// File: doc/BRIEF.md
# PHY Control-Port Register Responder

This block sits on the PHY side of a narrow control port. It serves a master that reaches a small set of configuration registers through one 20-bit control word and one 17-bit status word. The master moves a 16-bit value on a shared field and raises one of four strobes. The strobes are address capture, data capture, read and write. The responder acts on the strobe's rising edge, waits a configurable number of cycles, then raises acknowledge. It drops acknowledge once the master has released the strobe. Every phase of an access, including each capture, completes this four-phase handshake on its own.

Register access takes two steps. First the master latches an address, and then it either latches data and commits a write, or it requests a read. The register contents come back in the low 16 bits of the status word. The implemented registers are a sparse set of five 16-bit locations, each with a defined reset value. All other addresses read as zero and silently drop writes. The port carries no valid/ready pair. Acknowledge is the only flow control: the master may not start the next phase until acknowledge has fallen.

Top module: `phy_ctl_responder`

## Requirements
- R1: After reset the acknowledge bit (status bit 16) and the read field (status bits 15:0) are zero. The implemented registers hold their defaults: 0x0030=0x0091, 0x1002=0x0B7F, 0x1006=0x0342, 0x1010=0x0010, 0x102D=0x0080.
- R2: A rising edge on control bit 19 latches control bits 17:2 as the access address.
- R3: A rising edge on control bit 18 latches control bits 17:2 as the write data.
- R4: A rising edge on control bit 0 stores the latched data into the register at the latched address. The value field of the write word itself has no effect.
- R5: A rising edge on control bit 1 copies the register at the latched address into status bits 15:0. The field holds that value until the next read.
- R6: Acknowledge rises exactly LATENCY clock cycles after the edge at which the strobe's rise was sampled (LATENCY=3 by default).
- R7: Acknowledge stays high while the strobe that started the phase is held. It falls at the first edge that samples that strobe low.
- R8: A read of an unimplemented address returns zero. A write to one is acknowledged and leaves every implemented register unchanged.
- R9: Only rising edges act. Changing the value field while a strobe is held, or a rise seen while a phase is in progress, changes no latched state.
- R10: When several strobes rise together, only one is served, in the order address capture, data capture, write, read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 20 | Strobes at bits 19, 18, 1, 0; value field at bits 17:2 |
| stat_word | output | 17 | Bit 16 acknowledge; bits 15:0 read data |

## Verification
Each implemented register is first read for its default. A walking one is then written through all 16 bit positions, and a read after every write tells stuck or crossed data bits apart from address decode faults. Unimplemented neighbours of each implemented address receive writes and reads. These show whether decode is exact, and whether stray writes leak into real registers. Further patterns cover several cases: a write word whose value field differs from the latched data, a capture whose value field changes mid-phase, simultaneous address and data strobes that expose the priority order, and idle phases that show the read field holding. The handshake timing is measured on every transaction.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  localparam int VAL_W    = 16;
  localparam int WORD_W   = VAL_W + 4;
  localparam int NUM_REGS = 5;

  // strobe positions in the control word
  localparam int BIT_CAP_ADDR = WORD_W - 1;
  localparam int BIT_CAP_DATA = WORD_W - 2;
  localparam int BIT_RD       = 1;
  localparam int BIT_WR       = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } seq_st_t;

  function automatic logic [VAL_W-1:0] reg_addr(input int idx);
    case (idx)
      0:       return 16'h0030;
      1:       return 16'h1002;
      2:       return 16'h1006;
      3:       return 16'h1010;
      default: return 16'h102D;
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] reg_init(input int idx);
    case (idx)
      0:       return 16'h0091;
      1:       return 16'h0B7F;
      2:       return 16'h0342;
      3:       return 16'h0010;
      default: return 16'h0080;
    endcase
  endfunction

endpackage

// File: rtl/phy_ctl_seq.sv
module phy_ctl_seq
  import phy_ctl_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] strb,      // {cap_addr, cap_data, wr, rd}: index is priority
  output logic [3:0] fire,      // one-cycle pulse for the served strobe
  output logic       ack,
  output logic       in_wait,
  output logic       held
);

  localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY);

  seq_st_t       st_q;
  logic [3:0]    prev_q;
  logic [3:0]    kind_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    rise;
  logic [3:0]    pick;

  assign rise = strb & ~prev_q;

  always_comb begin
    pick = '0;
    for (int i = 3; i >= 0; i--) begin
      if (rise[i] && pick == '0) pick[i] = 1'b1;
    end
  end

  assign fire    = (st_q == ST_IDLE) ? pick : 4'b0000;
  assign held    = |(strb & kind_q);
  assign ack     = (st_q == ST_ACK);
  assign in_wait = (st_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prev_q <= '0;
      kind_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= strb;
      case (st_q)
        ST_IDLE: begin
          if (|fire) begin
            kind_q <= fire;
            cnt_q  <= '0;
            st_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt_q == CW'(LATENCY - 1)) st_q <= ST_ACK;
          else                           cnt_q <= cnt_q + 1'b1;
        end
        ST_ACK: begin
          if (!held) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] addr,
  input  logic [VAL_W-1:0] wdata,
  input  logic             we,
  output logic [VAL_W-1:0] rdata
);

  logic [VAL_W-1:0] hit_val [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [VAL_W-1:0] r_q;
    logic             sel;
    assign sel = (addr == reg_addr(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        r_q <= reg_init(g);
      else if (we && sel) r_q <= wdata;
    end

    assign hit_val[g] = sel ? r_q : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) rdata = rdata | hit_val[i];
  end

endmodule

// File: rtl/phy_ctl_responder.sv
module phy_ctl_responder
  import phy_ctl_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ctl_word,
  output logic [VAL_W:0]    stat_word
);

  logic [3:0]       strb;
  logic [3:0]       fire;
  logic             ack;
  logic             in_wait;
  logic             held;
  logic [VAL_W-1:0] value;
  logic [VAL_W-1:0] addr_q;
  logic [VAL_W-1:0] data_q;
  logic [VAL_W-1:0] rd_q;
  logic [VAL_W-1:0] reg_rdata;

  assign strb  = {ctl_word[BIT_CAP_ADDR], ctl_word[BIT_CAP_DATA],
                  ctl_word[BIT_WR], ctl_word[BIT_RD]};
  assign value = ctl_word[VAL_W+1:2];

  phy_ctl_seq #(.LATENCY(LATENCY)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .fire    (fire),
    .ack     (ack),
    .in_wait (in_wait),
    .held    (held)
  );

  phy_ctl_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr_q),
    .wdata (data_q),
    .we    (fire[1]),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      if (fire[3]) addr_q <= value;
      if (fire[2]) data_q <= value;
      if (fire[0]) rd_q   <= reg_rdata;
    end
  end

  assign stat_word = {ack, rd_q};

endmodule

// File: rtl/phy_ctl_responder_chk.sv
module phy_ctl_responder_chk #(
  parameter int LATENCY = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ack,
  input logic        in_wait,
  input logic        held,
  input logic [3:0]  fire,
  input logic [15:0] rd_field
);

  logic [15:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_cnt <= '0;
    else if (in_wait) wait_cnt <= wait_cnt + 1'b1;
    else              wait_cnt <= '0;
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> wait_cnt == 16'(LATENCY));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && held) |=> ack);

  a_r7_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !held) |=> !ack);

  a_r5_rd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !fire[0] |=> $stable(rd_field));

  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

  a_r9_no_fire_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || in_wait) |-> fire == 4'b0000);

endmodule

bind phy_ctl_responder phy_ctl_responder_chk #(.LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .in_wait  (in_wait),
  .held     (held),
  .fire     (fire),
  .rd_field (rd_q)
);

// File: tb/phy_ctl_responder_test.sv
`timescale 1ns/1ps
module phy_ctl_responder_test;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] ctl_word = '0;
  logic [16:0] stat_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] mdl_addr [5] = '{16'h0030, 16'h1002, 16'h1006, 16'h1010, 16'h102D};
  logic [15:0] mdl_val  [5] = '{16'h0091, 16'h0B7F, 16'h0342, 16'h0010, 16'h0080};

  always #2 clk = ~clk;

  phy_ctl_responder #(.LATENCY(LAT)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_word  (ctl_word),
    .stat_word (stat_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input bit a, input bit d, input bit rd,
                                     input bit wr, input logic [15:0] v);
    return {a, d, v, rd, wr};
  endfunction

  // one four-phase transaction; timing of acknowledge checked each time (R6, R7)
  task automatic xact(input logic [19:0] w);
    int n = 0;
    ctl_word = w;
    while (!stat_word[16] && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == LAT + 1, "R6 ack latency", n, LAT + 1);
    repeat (2) @(negedge clk);
    check(stat_word[16] == 1'b1, "R7 ack held", stat_word[16], 1);
    ctl_word = w & 20'h3FFFC;
    @(negedge clk);
    check(stat_word[16] == 1'b0, "R7 ack falls", stat_word[16], 0);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    xact(mk(1, 0, 0, 0, a));
    xact(mk(0, 0, 1, 0, a ^ 16'h5A5A));
    d = stat_word[15:0];
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] v);
    xact(mk(1, 0, 0, 0, a));
    xact(mk(0, 1, 0, 0, v));
    xact(mk(0, 0, 0, 1, ~v));   // value field of write word must be ignored (R4)
  endtask

  function automatic int mdl_idx(input logic [15:0] a);
    for (int i = 0; i < 5; i++) if (mdl_addr[i] == a) return i;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(stat_word == 17'h0, "R1 status after reset", stat_word, 0);
    for (int i = 0; i < 5; i++) begin
      rd(mdl_addr[i], d);
      check(d == mdl_val[i], "R1 default", d, mdl_val[i]);
    end

    // R2 R3 R4 R5 walking one on every implemented register
    for (int i = 0; i < 5; i++) begin
      for (int b = 0; b < 16; b++) begin
        logic [15:0] v = 16'h1 << b;
        wr(mdl_addr[i], v);
        mdl_val[i] = v;
        rd(mdl_addr[i], d);
        check(d == v, "R4 write/readback", d, v);
      end
    end

    // R8 unimplemented neighbours
    for (int i = 0; i < 5; i++) begin
      for (int off = -1; off <= 1; off += 2) begin
        logic [15:0] a = mdl_addr[i] + 16'(off);
        if (mdl_idx(a) < 0) begin
          wr(a, 16'hBEEF);
          rd(a, d);
          check(d == 16'h0, "R8 unimplemented reads zero", d, 0);
        end
      end
    end
    for (int i = 0; i < 5; i++) begin
      rd(mdl_addr[i], d);
      check(d == mdl_val[i], "R8 stray write leaked", d, mdl_val[i]);
    end

    // R5 read field holds across non-read phases
    rd(16'h1006, d);
    xact(mk(1, 0, 0, 0, 16'h0030));
    xact(mk(0, 1, 0, 0, 16'h7777));
    check(stat_word[15:0] == mdl_val[2], "R5 read field holds", stat_word[15:0], mdl_val[2]);

    // R9 value field changes while capture strobe held
    xact(mk(1, 0, 0, 0, 16'h0030));
    ctl_word = mk(0, 1, 0, 0, 16'h1234);
    @(negedge clk);
    ctl_word = mk(0, 1, 0, 0, 16'hABCD);
    while (!stat_word[16]) @(negedge clk);
    ctl_word = mk(0, 0, 0, 0, 16'hABCD);
    @(negedge clk);
    xact(mk(0, 0, 0, 1, 16'h0));
    mdl_val[0] = 16'h1234;
    rd(16'h0030, d);
    check(d == 16'h1234, "R9 level change ignored", d, 16'h1234);

    // R10 address and data capture rise together: only the address is taken
    xact(mk(1, 0, 0, 0, 16'h1010));
    xact(mk(0, 1, 0, 0, 16'h0F0F));
    xact(mk(1, 1, 0, 0, 16'h102D));
    xact(mk(0, 0, 0, 1, 16'h0));
    mdl_val[4] = 16'h0F0F;
    rd(16'h102D, d);
    check(d == 16'h0F0F, "R10 address taken, data kept", d, 16'h0F0F);
    rd(16'h1010, d);
    check(d == mdl_val[3], "R10 old address untouched", d, mdl_val[3]);

    // R10 write and read rise together: write served, read field unchanged
    rd(16'h1002, d);
    xact(mk(0, 1, 0, 0, 16'h2468));
    xact(mk(0, 0, 1, 1, 16'h0));
    check(stat_word[15:0] == mdl_val[1], "R10 read suppressed", stat_word[15:0], mdl_val[1]);
    rd(16'h1002, d);
    check(d == 16'h2468, "R10 write served", d, 16'h2468);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule